// File: doc/BRIEF.md
# Atomic Memory Ordering Issue Gate

This block sits between a core's in-order memory-op stream and the memory system. It decides, cycle by cycle, whether the op at the head of the stream may issue. Each op is either plain (load or store) or atomic. An atomic also carries a two-bit ordering attribute. The gate enforces acquire, release and sequentially consistent semantics by stalling issue. No separate fence instructions are involved.

The gate counts ops that were issued and have not yet finished. It remembers the one acquiring atomic that may be in flight. For a sequentially consistent atomic, it runs a system-wide sync request and acknowledge handshake before it reports that atomic as finished. Every issued op gets a sequential tag. The memory system returns completions by tag, and the gate passes them back to the core as done pulses.

Top module: `mem_order_gate`

## Requirements
- R1: For two or more cycles of synchronous reset, then release: the gate is idle. `op_ready` is high, `done_valid` and `sync_req` are low, and the next issue tag is 0.
- R2: An op issues (`issue_valid` = `op_valid` and `op_ready`) in the cycle it is presented, when neither R3 nor R4 nor R5 blocks it. Issue tags count up by one per issued op, modulo 2^ID_W.
- R3: An atomic whose `op_order[1]` (aq) bit is set sets a hold once it issues. While the hold is set, `op_ready` is low. The hold clears in the cycle after that atomic's done pulse.
- R4: An atomic whose `op_order[0]` (rl) bit is set is not ready while any issued op is still unfinished, i.e. has had no done pulse.
- R5: No more than MAX_OUT ops are unfinished at once. At that count `op_ready` is low.
- R6: Order 11 means sequentially consistent. When that atomic completes on `cmp_valid`/`cmp_tag`, no done pulse is produced that cycle. `sync_req` rises the next cycle and stays high until a cycle with `sync_ack` high. In that cycle `done_valid` pulses with the atomic's tag, and `sync_req` is low from the following cycle.
- R7: For a plain op (`op_atomic` = 0), the `op_order` bits are ignored. A plain op never sets the hold, never waits for the count to drain, and never causes `sync_req`.
- R8: Every other completion produces a done pulse in the same cycle with the same tag.
- R9: A relaxed atomic (order 00) is gated only by R3 and R5, exactly as a plain op is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Head op of the stream is present |
| op_ready | output | 1 | Gate allows the head op to issue |
| op_atomic | input | 1 | 1 = atomic, 0 = plain load/store |
| op_order | input | 2 | Bit 1 = aq, bit 0 = rl (00 relaxed, 01 release, 10 acquire, 11 seq_cst) |
| issue_valid | output | 1 | Head op issues this cycle |
| issue_tag | output | ID_W | Tag given to the issuing op |
| cmp_valid | input | 1 | Memory system finished an issued op |
| cmp_tag | input | ID_W | Tag of the finished op |
| done_valid | output | 1 | Op is finished as seen by the core |
| done_tag | output | ID_W | Tag of that op |
| sync_req | output | 1 | System-wide sync requested |
| sync_ack | input | 1 | System-wide sync performed |

## Verification
The assertions assume the environment behaves. It completes only tags that are outstanding, and each of them once. It raises `sync_ack` only while `sync_req` is high. It keeps an offered op stable until that op issues. The stimulus keeps to these rules by drawing completions only from its own list of tags still in flight, and by raising the acknowledge only when its model has a sync pending. It also holds a presented op until the cycle in which it issues.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;

    typedef enum logic [1:0] {
        ORD_RLX = 2'b00,
        ORD_REL = 2'b01,
        ORD_ACQ = 2'b10,
        ORD_SC  = 2'b11
    } ord_e;

    typedef struct packed {
        logic atomic;
        ord_e ord;
    } op_attr_t;

    // younger ops must wait for this one
    function automatic logic attr_acquires(op_attr_t a);
        return a.atomic && a.ord[1];
    endfunction

    // this op must wait for all older ones
    function automatic logic attr_releases(op_attr_t a);
        return a.atomic && a.ord[0];
    endfunction

    // this op needs a global sync before it is finished
    function automatic logic attr_syncs(op_attr_t a);
        return a.atomic && (a.ord == ORD_SC);
    endfunction

endpackage

// File: rtl/mog_inflight_ctr.sv
module mog_inflight_ctr #(
    parameter int MAX_OUT = 8,
    parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign empty = (cnt == '0);
    assign full  = (cnt == LIMIT);
endmodule

// File: rtl/mog_acq_hold.sv
module mog_acq_hold #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic [ID_W-1:0] set_tag,
    input  logic            set_sc,
    input  logic            done_valid,
    input  logic [ID_W-1:0] done_tag,
    output logic            hold,
    output logic [ID_W-1:0] hold_tag,
    output logic            hold_sc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= 1'b0;
            hold_tag <= '0;
            hold_sc  <= 1'b0;
        end else if (set) begin
            hold     <= 1'b1;
            hold_tag <= set_tag;
            hold_sc  <= set_sc;
        end else if (hold && done_valid && (done_tag == hold_tag)) begin
            hold    <= 1'b0;
            hold_sc <= 1'b0;
        end
    end
endmodule

// File: rtl/mog_sync_ctl.sv
module mog_sync_ctl #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmp_valid,
    input  logic [ID_W-1:0] cmp_tag,
    input  logic            hold,
    input  logic [ID_W-1:0] hold_tag,
    input  logic            hold_sc,
    input  logic            sync_ack,
    output logic            cmp_swallow,
    output logic            sync_req,
    output logic            sync_done
);
    // memory finished the seq_cst atomic: keep it open until sync is acknowledged
    assign cmp_swallow = cmp_valid && hold && hold_sc && (cmp_tag == hold_tag);
    assign sync_done   = sync_req && sync_ack;

    always_ff @(posedge clk) begin
        if (rst)              sync_req <= 1'b0;
        else if (cmp_swallow) sync_req <= 1'b1;
        else if (sync_done)   sync_req <= 1'b0;
    end
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
    import mem_order_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int MAX_OUT = 8,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic            op_atomic,
    input  logic [1:0]      op_order,
    output logic            issue_valid,
    output logic [ID_W-1:0] issue_tag,
    input  logic            cmp_valid,
    input  logic [ID_W-1:0] cmp_tag,
    output logic            done_valid,
    output logic [ID_W-1:0] done_tag,
    output logic            sync_req,
    input  logic            sync_ack
);
    op_attr_t         attr;
    logic             want_acq, want_rel, want_sync;
    logic [CNT_W-1:0] inflight_cnt;
    logic             cnt_empty, cnt_full;
    logic             acq_hold_q, hold_sc;
    logic [ID_W-1:0]  hold_tag;
    logic             cmp_swallow, sync_done;
    logic [ID_W-1:0]  next_tag;

    assign attr      = '{atomic: op_atomic, ord: ord_e'(op_order)};
    assign want_acq  = attr_acquires(attr);
    assign want_rel  = attr_releases(attr);
    assign want_sync = attr_syncs(attr);

    assign op_ready    = !acq_hold_q && !cnt_full && !(want_rel && !cnt_empty);
    assign issue_valid = op_valid && op_ready;
    assign issue_tag   = next_tag;

    always_ff @(posedge clk) begin
        if (rst)              next_tag <= '0;
        else if (issue_valid) next_tag <= next_tag + 1'b1;
    end

    assign done_valid = (cmp_valid && !cmp_swallow) || sync_done;
    assign done_tag   = sync_done ? hold_tag : cmp_tag;

    mog_inflight_ctr #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .inc   (issue_valid),
        .dec   (done_valid),
        .cnt   (inflight_cnt),
        .empty (cnt_empty),
        .full  (cnt_full)
    );

    mog_acq_hold #(.ID_W(ID_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .set        (issue_valid && want_acq),
        .set_tag    (next_tag),
        .set_sc     (want_sync),
        .done_valid (done_valid),
        .done_tag   (done_tag),
        .hold       (acq_hold_q),
        .hold_tag   (hold_tag),
        .hold_sc    (hold_sc)
    );

    mog_sync_ctl #(.ID_W(ID_W)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .cmp_valid   (cmp_valid),
        .cmp_tag     (cmp_tag),
        .hold        (acq_hold_q),
        .hold_tag    (hold_tag),
        .hold_sc     (hold_sc),
        .sync_ack    (sync_ack),
        .cmp_swallow (cmp_swallow),
        .sync_req    (sync_req),
        .sync_done   (sync_done)
    );
endmodule

// File: rtl/mem_order_gate_chk.sv
module mem_order_gate_chk #(
    parameter int MAX_OUT = 8,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             op_atomic,
    input logic [1:0]       op_order,
    input logic             issue_valid,
    input logic             cmp_valid,
    input logic             done_valid,
    input logic             sync_req,
    input logic             sync_ack,
    input logic [CNT_W-1:0] cnt,
    input logic             acq_hold
);
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_OUT));

    // R3
    acq_block_chk: assert property (@(posedge clk) disable iff (rst)
        acq_hold |-> !issue_valid);

    // R4
    rel_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && op_atomic && op_order[0]) |-> (cnt == '0));

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_req && !sync_ack) |=> sync_req);

    // R6
    sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_req) |-> $past(cmp_valid));

    // R7
    sync_owner_chk: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> acq_hold);

    // R8
    done_inflight_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (cnt != '0));
endmodule

bind mem_order_gate mem_order_gate_chk #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_atomic   (op_atomic),
    .op_order    (op_order),
    .issue_valid (issue_valid),
    .cmp_valid   (cmp_valid),
    .done_valid  (done_valid),
    .sync_req    (sync_req),
    .sync_ack    (sync_ack),
    .cnt         (inflight_cnt),
    .acq_hold    (acq_hold_q)
);

// File: tb/mem_order_gate_tb.sv
module mem_order_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W       = 4;
    localparam int MAX_OUT    = 8;
    localparam int NTAG       = 1 << ID_W;

    logic            clk = 1'b0;
    logic            rst;
    logic            op_valid, op_ready, op_atomic;
    logic [1:0]      op_order;
    logic            issue_valid;
    logic [ID_W-1:0] issue_tag;
    logic            cmp_valid;
    logic [ID_W-1:0] cmp_tag;
    logic            done_valid;
    logic [ID_W-1:0] done_tag;
    logic            sync_req, sync_ack;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt, m_next, m_hold_tag;
    bit m_hold, m_hold_sc, m_sync;
    int pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_order_gate #(.ID_W(ID_W), .MAX_OUT(MAX_OUT)) u_dut (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_ready(op_ready),
        .op_atomic(op_atomic), .op_order(op_order),
        .issue_valid(issue_valid), .issue_tag(issue_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .sync_req(sync_req), .sync_ack(sync_ack)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog R2: actual hung expected finished run");
        summary();
        $finish;
    end

    task automatic run_phase(int ncyc, int p_op, int p_cmp, int p_atom, int p_ack);
        int  idx;
        bit  e_ready, e_issue, e_swallow, e_sdone, e_done;
        int  e_dtag;
        bit  acq, rel;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            @(negedge clk);
            if (!op_valid && ($urandom_range(99) < p_op)) begin
                op_valid  = 1'b1;
                op_atomic = ($urandom_range(99) < p_atom);
                op_order  = 2'($urandom_range(3));   // plain ops get random bits too (R7)
            end
            cmp_valid = 1'b0;
            idx = -1;
            if (pend.size() > 0 && ($urandom_range(99) < p_cmp)) begin
                idx       = $urandom_range(pend.size() - 1);
                cmp_valid = 1'b1;
                cmp_tag   = ID_W'(pend[idx]);
            end
            sync_ack = m_sync && ($urandom_range(99) < p_ack);
            #1;
            // expectations from the requirements
            acq = op_atomic && op_order[1];
            rel = op_atomic && op_order[0];
            e_ready   = !m_hold && (m_cnt < MAX_OUT) && !(rel && m_cnt != 0);
            e_issue   = op_valid && e_ready;
            e_swallow = cmp_valid && m_hold && m_hold_sc && (int'(cmp_tag) == m_hold_tag);
            e_sdone   = m_sync && sync_ack;
            e_done    = (cmp_valid && !e_swallow) || e_sdone;
            e_dtag    = e_sdone ? m_hold_tag : int'(cmp_tag);
            check("R2 R3 R4 R5 R7 R9", "op_ready", op_ready, e_ready);
            check("R2", "issue_valid", issue_valid, e_issue);
            if (op_valid) check("R2", "issue_tag", issue_tag, m_next);
            check("R6 R7", "sync_req", sync_req, m_sync);
            check("R6 R8", "done_valid", done_valid, e_done);
            if (e_done) check("R6 R8", "done_tag", done_tag, e_dtag);
            @(posedge clk);
            // model update
            m_cnt = m_cnt + (e_issue ? 1 : 0) - (e_done ? 1 : 0);
            if (e_done && m_hold && e_dtag == m_hold_tag) begin
                m_hold = 0; m_hold_sc = 0;
            end
            if (e_issue) begin
                pend.push_back(m_next);
                if (acq) begin
                    m_hold = 1; m_hold_tag = m_next; m_hold_sc = op_order[0];
                end
                m_next = (m_next + 1) % NTAG;
            end
            if (idx >= 0) pend.delete(idx);
            if (e_swallow)    m_sync = 1;
            else if (e_sdone) m_sync = 0;
            if (e_issue) begin
                #1 op_valid = 1'b0;
            end
        end
    endtask

    initial begin
        rst = 1'b1;
        op_valid = 0; op_atomic = 0; op_order = 2'b00;
        cmp_valid = 0; cmp_tag = '0; sync_ack = 0;
        m_cnt = 0; m_next = 0; m_hold = 0; m_hold_tag = 0; m_hold_sc = 0; m_sync = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        op_atomic = 1'b1; op_order = 2'b11;
        #1;
        // R1
        check("R1", "op_ready after reset", op_ready, 1);
        check("R1", "sync_req after reset", sync_req, 0);
        check("R1", "done_valid after reset", done_valid, 0);
        check("R1", "issue_tag after reset", issue_tag, 0);
        op_atomic = 1'b0; op_order = 2'b00;

        run_phase(1500, 90, 35, 0,  50);   // plain traffic, tags wrap (R2 R7)
        run_phase(1500, 95, 4,  10, 50);   // slow memory, fills to limit (R5)
        run_phase(1500, 70, 40, 60, 40);   // atomic mix (R3 R4 R6 R9)
        run_phase(1500, 85, 20, 35, 15);   // long sync waits (R6 R8)

        // drain with no new ops
        run_phase(200, 0, 60, 0, 60);
        check("R8", "all ops finished", m_cnt, 0);
        check("R5", "inflight equals pending list", pend.size(), m_cnt);
        summary();
        $finish;
    end
endmodule